// File: doc/BRIEF.md
# External Sample-Trigger Controller

This block sequences a converter's sample/hold stage from an external, active-low trigger line in the asynchronous, extended sampling mode. When the trigger line goes low, the sample/hold circuit is opened and tracks the selected channel. When the line returns high, the circuit is put into hold and a conversion is started. The sampling period is therefore exactly as long as the host keeps the line low. The conversion is finished when the conversion engine raises a done input.

The trigger line is not tied to the serial port. Chip-select, frame-sync and serial clock activity have no effect on it. There is one exception. The serial interface supplies its count of serial-clock rising edges, and no trigger is accepted until that count has reached the unlock value (eleven). Three kinds of trigger misuse are reported. Each report is a sticky flag that only reset clears:

- a trigger that arrives too early;
- a trigger that arrives while a conversion is still running;
- a low pulse shorter than a programmable minimum.

The trigger input is synchronised to the system clock inside the block. Every output is registered.

Top module: `smp_trig_ctrl`

## Requirements
- R1: While and directly after reset: `sh_hold` is 1, `conv_start` is 0, and all three error flags are 0.
- R2: Once armed and idle, a falling edge on `trig_n` drives `sh_hold` to 0 (sampling). The change appears on the third rising clock edge after the input changes: two synchroniser stages, then the state register.
- R3: A rising edge on `trig_n` while sampling sets `sh_hold` to 1. On that same clock edge, `conv_start` is asserted for exactly one clock cycle.
- R4: After a conversion starts, `sh_hold` stays 1 and no further `conv_start` pulse occurs until `conv_done` is sampled high. After that, the block is idle and a new falling edge is accepted.
- R5: While `sclk_edges` is below 11, a falling edge on `trig_n` is ignored: `sh_hold` stays 1. It also sets `err_early`. A count of exactly 10 is still locked; a count of 11 or more unlocks.
- R6: Once `sclk_edges` has reached 11, the block stays unlocked even if the count later drops back to 0.
- R7: A falling edge on `trig_n` during a conversion is ignored: no new sampling, no extra `conv_start`. It also sets `err_overrun`. If the line rises again before the block is back in idle, no conversion is started.
- R8: If the synchronised low time is shorter than `min_low` clock cycles, `err_short` is set and the conversion still starts with one `conv_start` pulse.
- R9: A low time of exactly `min_low` cycles starts the conversion without setting `err_short`.
- R10: `err_early`, `err_overrun` and `err_short` remain set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | External active-low sampling trigger, asynchronous |
| conv_done | input | 1 | Conversion finished indication |
| sclk_edges | input | 5 | Serial-clock rising-edge count from the serial interface |
| min_low | input | 8 | Minimum trigger low time, in clock cycles |
| sh_hold | output | 1 | 1 = hold, 0 = sampling |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| err_early | output | 1 | Sticky: trigger arrived before unlock |
| err_overrun | output | 1 | Sticky: trigger arrived during a conversion |
| err_short | output | 1 | Sticky: low time below the minimum |

## Verification
The hardest situation to reach is a second trigger during an unfinished conversion. The bench starts a conversion and keeps `conv_done` low. It then drops the trigger, ends the conversion while the line is still low, and releases the line while the block is back in idle. This shows that neither edge starts sampling or a conversion. The lockout boundary is reached by holding the edge count at 10 and then lifting it to 11 and back to 0 before the first valid trigger.

// File: rtl/smp_trig_pkg.sv
package smp_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } trig_state_e;
endpackage

// File: rtl/smp_trig_sync.sv
// Brings the asynchronous trigger into the clock domain and detects its edges.
module smp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              level;

  assign level = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], trig_n};
      prev  <= level;
    end
  end

  assign fall = prev & ~level;
  assign rise = ~prev & level;
endmodule

// File: rtl/smp_trig_arm.sv
// Unlocks triggering once the serial clock count reaches the threshold; stays unlocked.
module smp_trig_arm #(
  parameter int EDGE_W      = 5,
  parameter int UNLOCK_EDGE = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EDGE_W-1:0] sclk_edges,
  output logic              armed
);
  localparam logic [EDGE_W-1:0] THRESH = EDGE_W'(UNLOCK_EDGE);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (sclk_edges >= THRESH) armed <= 1'b1;
  end
endmodule

// File: rtl/smp_trig_lowtmr.sv
// Measures the sampling window length; saturates at its maximum.
module smp_trig_lowtmr #(
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [LOW_W-1:0] min_low,
  output logic             too_short
);
  localparam logic [LOW_W-1:0] CNT_MAX = '1;
  localparam logic [LOW_W-1:0] CNT_ONE = LOW_W'(1);
  logic [LOW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start) cnt <= CNT_ONE;
    else if (run && cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
  end

  assign too_short = cnt < min_low;
endmodule

// File: rtl/smp_trig_ctrl.sv
module smp_trig_ctrl
  import smp_trig_pkg::*;
#(
  parameter int EDGE_W      = 5,
  parameter int UNLOCK_EDGE = 11,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_n,
  input  logic              conv_done,
  input  logic [EDGE_W-1:0] sclk_edges,
  input  logic [LOW_W-1:0]  min_low,
  output logic              sh_hold,
  output logic              conv_start,
  output logic              err_early,
  output logic              err_overrun,
  output logic              err_short
);
  trig_state_e state;
  logic fall, rise, armed, too_short, accept;

  smp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_n(trig_n), .fall(fall), .rise(rise)
  );

  smp_trig_arm #(.EDGE_W(EDGE_W), .UNLOCK_EDGE(UNLOCK_EDGE)) u_arm (
    .clk(clk), .rst(rst), .sclk_edges(sclk_edges), .armed(armed)
  );

  assign accept = (state == ST_IDLE) && fall && armed;

  smp_trig_lowtmr #(.LOW_W(LOW_W)) u_tmr (
    .clk(clk), .rst(rst), .start(accept), .run(state == ST_SAMPLE),
    .min_low(min_low), .too_short(too_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sh_hold     <= 1'b1;
      conv_start  <= 1'b0;
      err_early   <= 1'b0;
      err_overrun <= 1'b0;
      err_short   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SAMPLE;
            sh_hold <= 1'b0;
          end else if (fall) begin
            err_early <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (rise) begin
            state      <= ST_CONVERT;
            sh_hold    <= 1'b1;
            conv_start <= 1'b1;
            if (too_short) err_short <= 1'b1;
          end
        end
        ST_CONVERT: begin
          if (fall) err_overrun <= 1'b1;
          if (conv_done) state <= ST_IDLE;
        end
        default: begin
          state   <= ST_IDLE;
          sh_hold <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/smp_trig_ctrl_chk.sv
module smp_trig_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sh_hold,
  input logic conv_start,
  input logic err_early,
  input logic err_overrun,
  input logic err_short
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sh_hold && !conv_start && !err_early && !err_overrun && !err_short));

  // R3
  start_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (sh_hold && !$past(sh_hold)));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R5
  early_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_early) |-> sh_hold);

  // R10
  early_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_early |=> err_early);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_overrun |=> err_overrun);

  // R10
  short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_short |=> err_short);

  // R8
  short_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_short) |-> conv_start);
endmodule

bind smp_trig_ctrl smp_trig_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .sh_hold(sh_hold), .conv_start(conv_start),
  .err_early(err_early), .err_overrun(err_overrun), .err_short(err_short)
);

// File: tb/smp_trig_ctrl_tb.sv
module smp_trig_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_n = 1'b1;
  logic       conv_done = 1'b0;
  logic [4:0] sclk_edges = '0;
  logic [7:0] min_low = 8'd8;
  logic       sh_hold, conv_start, err_early, err_overrun, err_short;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  smp_trig_ctrl u_dut (
    .clk(clk), .rst(rst), .trig_n(trig_n), .conv_done(conv_done),
    .sclk_edges(sclk_edges), .min_low(min_low), .sh_hold(sh_hold),
    .conv_start(conv_start), .err_early(err_early),
    .err_overrun(err_overrun), .err_short(err_short)
  );

  always @(negedge clk) if (!rst && conv_start) pulses++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic end_conv();
    conv_done = 1'b1;
    step(1);
    conv_done = 1'b0;
    step(2);
  endtask

  // Low pulse of len cycles; checks sampling, then hold plus one start pulse.
  task automatic pulse_low(input int len, input string tag);
    int p0;
    p0 = pulses;
    trig_n = 1'b0;
    step(3);
    chk(sh_hold, 0, {tag, " sampling after fall (R2)"});
    step(len - 3);
    trig_n = 1'b1;
    step(5);
    chk(sh_hold, 1, {tag, " hold after rise (R3)"});
    chk(pulses - p0, 1, {tag, " one conv_start pulse (R3)"});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    chk(sh_hold, 1, "R1 sh_hold after reset");
    chk(conv_start, 0, "R1 conv_start after reset");
    chk({err_early, err_overrun, err_short}, 0, "R1 flags after reset");
  endtask

  task automatic t_early();
    sclk_edges = 5'd10;
    step(2);
    trig_n = 1'b0;
    step(5);
    chk(sh_hold, 1, "R5 early fall ignored");
    chk(err_early, 1, "R5 early flag set");
    trig_n = 1'b1;
    step(5);
    chk(pulses, 0, "R5 no conversion from early trigger");
    sclk_edges = 5'd11;
    step(2);
    sclk_edges = 5'd0;
    step(2);
  endtask

  task automatic t_normal();
    int p0;
    pulse_low(10, "R6 unlocked after count drop");
    chk(err_short, 0, "R8 long pulse no short flag");
    p0 = pulses;
    step(10);
    chk(sh_hold, 1, "R4 hold while converting");
    chk(pulses - p0, 0, "R4 no extra pulse before done");
    end_conv();
    pulse_low(8, "R4 retrigger after done");
    chk(err_short, 0, "R9 exact min_low no short flag");
    end_conv();
  endtask

  task automatic t_overrun();
    int p0;
    pulse_low(10, "R7 setup");
    p0 = pulses;
    trig_n = 1'b0;
    step(5);
    chk(sh_hold, 1, "R7 fall in convert ignored");
    chk(err_overrun, 1, "R7 overrun flag set");
    end_conv();
    trig_n = 1'b1;
    step(6);
    chk(sh_hold, 1, "R7 stale rise does not sample");
    chk(pulses - p0, 0, "R7 no conversion from stale trigger");
  endtask

  task automatic t_short();
    pulse_low(4, "R8 short pulse");
    chk(err_short, 1, "R8 short flag set");
    chk(err_early, 1, "R10 early flag still set");
    chk(err_overrun, 1, "R10 overrun flag still set");
    end_conv();
    chk(err_short, 1, "R10 short flag still set");
  endtask

  initial begin
    t_reset();
    t_early();
    t_normal();
    t_overrun();
    t_short();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule